// File: doc/BRIEF.md
# OEM Request Frame Checker and Response Header Builder

This block sits behind a block-transfer style message transport and takes in one vendor-extension request at a time as a byte stream with valid and last markers. It checks the fixed header and reports whether it is good: a length byte, a function byte whose upper six bits must hold the vendor-request code and whose lower two bits carry a logical unit number, a sequence byte, a command byte, and a three-byte vendor number sent least significant byte first. Once the whole header has been checked, the command, unit number and sequence are presented. Bytes after the header are forwarded as a payload stream. A single flag at the end of the frame reports a bad header, a frame that is too short, or a byte count that does not match the length byte.

A second, independent port builds the reply. The caller gives a completion code and the number of reply data bytes and pulses a start strobe. The block then sends one eight-byte reply header followed by the caller's data bytes, which it pulls one per cycle with a take strobe. The reply header holds the computed length, the vendor-response function code with the mirrored unit number, the mirrored sequence and command, the completion code and the vendor number.

Top module: `oemreq_frame_chk`

## Requirements
- R1: After reset, hdr_vld, pay_vld, pay_last, frame_done, frame_err, rs_take, rs_busy, tx_vld and tx_last are low, and cmd_code, req_lun and req_seq are zero.
- R2: Request beat 0 is the length byte and beat 1 holds the function code in bits 7:2 and the unit number in bits 1:0. The function code must equal 0x2E, and every unit number is accepted. Beat 2 is the sequence and beat 3 the command. hdr_vld pulses for one cycle, in the cycle after beat 6, only when the whole header is good.
- R3: Beats 4, 5 and 6 must be 0xCF, 0xC2 and 0x00, in that order. Any other value makes the header bad.
- R4: Command values 1 to 4 are accepted. Command 0 and commands 5 to 255 make the header bad.
- R5: When the header is good, each beat from beat 7 onward appears on pay_byte with pay_vld one cycle later, and pay_last marks the final beat. When the header is bad, pay_vld stays low for the whole frame.
- R6: frame_done pulses one cycle after the beat that carries rq_last. frame_err goes high with it when the header is bad, when the frame has fewer than 7 beats, or when the beat count differs from the length byte plus one.
- R7: Cycles with rq_vld low have no effect on parsing. A frame with idle cycles between its beats gives the same results as the same frame sent without gaps.
- R8: The beat after a beat with rq_last is beat 0 of a new frame, including when no idle cycle separates the frames.
- R9: When rs_start is high and rs_busy is low, the block accepts the start. tx_vld then rises two cycles later and carries these reply bytes: 7+rs_n, {0x2F, unit}, sequence, command, rs_cc, 0xCF, 0xC2, 0x00. rs_n must not exceed 248.
- R10: After the header, rs_take is high in each cycle in which rs_dat is sampled, and that byte appears on tx_byte in the next cycle. rs_take is never high while rs_busy is low.
- R11: The reply is sent on consecutive cycles, and tx_last marks its final byte. With rs_n equal to 0, the reply ends on header byte 7.
- R12: rs_start while rs_busy is high is ignored, and the reply in progress continues unchanged.
- R13: cmd_code, req_lun and req_seq, and the values mirrored into the reply, change only when a good header completes. A bad frame leaves them at the values from the last good header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_vld | input | 1 | Request byte valid |
| rq_byte | input | 8 | Request byte |
| rq_last | input | 1 | Final byte of request frame |
| hdr_vld | output | 1 | Pulse: header checked and good |
| cmd_code | output | 8 | Command of last good header |
| req_lun | output | 2 | Unit number of last good header |
| req_seq | output | 8 | Sequence of last good header |
| pay_vld | output | 1 | Payload byte valid |
| pay_byte | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte |
| frame_done | output | 1 | Pulse: request frame ended |
| frame_err | output | 1 | Frame bad, valid with frame_done |
| rs_start | input | 1 | Start a reply |
| rs_cc | input | 8 | Completion code for the reply |
| rs_n | input | 8 | Number of reply data bytes |
| rs_dat | input | 8 | Reply data byte, sampled when rs_take |
| rs_take | output | 1 | rs_dat consumed this cycle |
| rs_busy | output | 1 | Reply in progress |
| tx_vld | output | 1 | Reply byte valid |
| tx_byte | output | 8 | Reply byte |
| tx_last | output | 1 | Final reply byte |

## Verification
The properties assume that rq_last is only high together with rq_vld, that rs_n stays at 248 or below so the length byte cannot wrap, and that rs_dat holds the correct next byte whenever rs_take is high. The stimulus keeps to these rules. Every request beat is driven with its last marker set only on the final valid beat. Reply sizes are chosen well under the limit. Reply data comes from a function of the byte index that the bench applies in the cycle in which the model expects a take.

// File: rtl/oemreq_pkg.sv
package oemreq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned BYTE_W        = 8;
  localparam logic [5:0]  NETFN_OEM_REQ = 6'h2E;
  localparam logic [5:0]  NETFN_OEM_RSP = 6'h2F;
  localparam logic [23:0] VENDOR_NUM    = 24'd49871;
  localparam int unsigned REQ_HDR_BYTES = 7;
  localparam int unsigned RSP_HDR_BYTES = 8;
  localparam int unsigned CMD_LOWEST    = 1;
  localparam int unsigned CMD_HIGHEST   = 4;

  // vendor number is serialized low byte first
  function automatic logic [7:0] vendor_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    return VENDOR_NUM[7:0];
      2'd1:    return VENDOR_NUM[15:8];
      default: return VENDOR_NUM[23:16];
    endcase
  endfunction

  function automatic logic cmd_allocated(input logic [7:0] c);
    return (c >= 8'(CMD_LOWEST)) && (c <= 8'(CMD_HIGHEST));
  endfunction

  // bytes that follow the length byte: rest of header plus data
  function automatic logic [7:0] rsp_len_byte(input logic [7:0] n);
    return 8'(RSP_HDR_BYTES - 1) + n;
  endfunction

  function automatic logic [7:0] rsp_hdr_byte(input logic [2:0] pos,
                                              input logic [7:0] n,
                                              input logic [1:0] lun,
                                              input logic [7:0] seq,
                                              input logic [7:0] cmd,
                                              input logic [7:0] cc);
    case (pos)
      3'd0:    return rsp_len_byte(n);
      3'd1:    return {NETFN_OEM_RSP, lun};
      3'd2:    return seq;
      3'd3:    return cmd;
      3'd4:    return cc;
      3'd5:    return vendor_byte(2'd0);
      3'd6:    return vendor_byte(2'd1);
      default: return vendor_byte(2'd2);
    endcase
  endfunction
endpackage

// File: rtl/oemreq_beat_ctr.sv
module oemreq_beat_ctr #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  output logic [W-1:0] cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= '0;
    else if (step && cnt != CNT_TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/oemreq_rx_parse.sv
module oemreq_rx_parse
  import oemreq_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_last,
  output logic              hdr_vld,
  output logic [BYTE_W-1:0] cmd_code,
  output logic [1:0]        req_lun,
  output logic [BYTE_W-1:0] req_seq,
  output logic              pay_vld,
  output logic [BYTE_W-1:0] pay_byte,
  output logic              pay_last,
  output logic              frame_done,
  output logic              frame_err,
  output logic              hdr_pass_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [IDX_W-1:0] IDX_HDR_END = IDX_W'(REQ_HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_PAY0    = IDX_W'(REQ_HDR_BYTES);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] len_q, seq_t, cmd_t, len_now;
  logic [1:0]        lun_t;
  logic              bad_q, hdr_ok_q;
  logic              bad_now, bad_next, hdr_done_w, hdr_pass_w;
  logic              past_hdr_w, hdr_ok_eff, len_ok_w, end_bad_w, pass_pay_w;

  oemreq_beat_ctr #(.W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (in_vld & in_last),
    .step    (in_vld),
    .cnt     (idx)
  );

  always_comb begin
    bad_now = 1'b0;
    if (idx == IDX_W'(1))
      bad_now = (in_byte[7:2] != NETFN_OEM_REQ);
    else if (idx == IDX_W'(3))
      bad_now = !cmd_allocated(in_byte);
    else if (idx >= IDX_W'(4) && idx <= IDX_HDR_END)
      bad_now = (in_byte != vendor_byte(2'(idx - IDX_W'(4))));
  end

  assign len_now    = (idx == '0) ? in_byte : len_q;
  assign bad_next   = ((idx == '0) ? 1'b0 : bad_q) | bad_now;
  assign hdr_done_w = in_vld && (idx == IDX_HDR_END);
  assign hdr_pass_w = hdr_done_w && !bad_next;
  assign past_hdr_w = (idx >= IDX_PAY0);
  assign hdr_ok_eff = past_hdr_w ? hdr_ok_q : hdr_pass_w;
  assign len_ok_w   = (idx == IDX_W'(len_now));
  assign end_bad_w  = !(hdr_ok_eff && len_ok_w);
  assign pass_pay_w = in_vld && past_hdr_w && hdr_ok_q;
  assign hdr_pass_o = hdr_pass_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      lun_t    <= '0;
      seq_t    <= '0;
      cmd_t    <= '0;
      bad_q    <= 1'b0;
      hdr_ok_q <= 1'b0;
    end else if (in_vld) begin
      bad_q <= bad_next;
      if (idx == IDX_W'(0)) len_q <= in_byte;
      if (idx == IDX_W'(1)) lun_t <= in_byte[1:0];
      if (idx == IDX_W'(2)) seq_t <= in_byte;
      if (idx == IDX_W'(3)) cmd_t <= in_byte;
      if (in_last)         hdr_ok_q <= 1'b0;
      else if (hdr_done_w) hdr_ok_q <= !bad_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_vld    <= 1'b0;
      cmd_code   <= '0;
      req_lun    <= '0;
      req_seq    <= '0;
      pay_vld    <= 1'b0;
      pay_byte   <= '0;
      pay_last   <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      hdr_vld    <= hdr_pass_w;
      pay_vld    <= pass_pay_w;
      pay_last   <= pass_pay_w && in_last;
      frame_done <= in_vld && in_last;
      frame_err  <= in_vld && in_last && end_bad_w;
      if (pass_pay_w) pay_byte <= in_byte;
      if (hdr_pass_w) begin
        cmd_code <= cmd_t;
        req_lun  <= lun_t;
        req_seq  <= seq_t;
      end
    end
  end
endmodule

// File: rtl/oemreq_tx_build.sv
module oemreq_tx_build
  import oemreq_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] cc,
  input  logic [BYTE_W-1:0] n,
  input  logic [1:0]        lun,
  input  logic [BYTE_W-1:0] seq,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] dat,
  output logic              take,
  output logic              busy,
  output logic              tx_vld,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_last,
  output logic              accept_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [IDX_W-1:0] IDX_HDR_CNT = IDX_W'(RSP_HDR_BYTES);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] cc_q, n_q, seq_q, cmd_q, byte_w;
  logic [1:0]        lun_q;
  logic              accept_w, in_hdr_w, last_w;

  assign accept_w = start && !busy;
  assign accept_o = accept_w;

  oemreq_beat_ctr #(.W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_w),
    .step    (busy),
    .cnt     (idx)
  );

  assign in_hdr_w = (idx < IDX_HDR_CNT);
  assign last_w   = busy && (idx == IDX_HDR_CNT - IDX_W'(1) + IDX_W'(n_q));
  assign take     = busy && !in_hdr_w;
  assign byte_w   = in_hdr_w ? rsp_hdr_byte(idx[2:0], n_q, lun_q, seq_q, cmd_q, cc_q)
                             : dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cc_q    <= '0;
      n_q     <= '0;
      lun_q   <= '0;
      seq_q   <= '0;
      cmd_q   <= '0;
      tx_vld  <= 1'b0;
      tx_byte <= '0;
      tx_last <= 1'b0;
    end else begin
      if (accept_w) begin
        busy  <= 1'b1;
        cc_q  <= cc;
        n_q   <= n;
        lun_q <= lun;
        seq_q <= seq;
        cmd_q <= cmd;
      end else if (last_w) begin
        busy <= 1'b0;
      end
      tx_vld  <= busy;
      tx_last <= last_w;
      if (busy) tx_byte <= byte_w;
    end
  end
endmodule

// File: rtl/oemreq_frame_chk.sv
module oemreq_frame_chk
  import oemreq_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rq_vld,
  input  logic [7:0] rq_byte,
  input  logic       rq_last,
  output logic       hdr_vld,
  output logic [7:0] cmd_code,
  output logic [1:0] req_lun,
  output logic [7:0] req_seq,
  output logic       pay_vld,
  output logic [7:0] pay_byte,
  output logic       pay_last,
  output logic       frame_done,
  output logic       frame_err,
  input  logic       rs_start,
  input  logic [7:0] rs_cc,
  input  logic [7:0] rs_n,
  input  logic [7:0] rs_dat,
  output logic       rs_take,
  output logic       rs_busy,
  output logic       tx_vld,
  output logic [7:0] tx_byte,
  output logic       tx_last
);
  timeunit 1ns;
  timeprecision 1ps;

  // named internal events, observed by the bound checker
  logic rx_hdr_pass;
  logic rs_accept;

  oemreq_rx_parse #(.IDX_W(IDX_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (rq_vld),
    .in_byte    (rq_byte),
    .in_last    (rq_last),
    .hdr_vld    (hdr_vld),
    .cmd_code   (cmd_code),
    .req_lun    (req_lun),
    .req_seq    (req_seq),
    .pay_vld    (pay_vld),
    .pay_byte   (pay_byte),
    .pay_last   (pay_last),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .hdr_pass_o (rx_hdr_pass)
  );

  oemreq_tx_build #(.IDX_W(IDX_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rs_start),
    .cc       (rs_cc),
    .n        (rs_n),
    .lun      (req_lun),
    .seq      (req_seq),
    .cmd      (cmd_code),
    .dat      (rs_dat),
    .take     (rs_take),
    .busy     (rs_busy),
    .tx_vld   (tx_vld),
    .tx_byte  (tx_byte),
    .tx_last  (tx_last),
    .accept_o (rs_accept)
  );
endmodule

// File: rtl/oemreq_frame_chk_sva.sv
module oemreq_frame_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       rq_vld,
  input logic       hdr_vld,
  input logic [7:0] cmd_code,
  input logic       pay_vld,
  input logic       pay_last,
  input logic       frame_done,
  input logic       frame_err,
  input logic       rx_hdr_pass,
  input logic       rs_accept,
  input logic       rs_take,
  input logic       rs_busy,
  input logic       tx_vld,
  input logic [7:0] tx_byte,
  input logic       tx_last
);
  timeunit 1ns;
  timeprecision 1ps;

  logic seen_hdr, in_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_hdr <= 1'b0;
    else if (frame_done) seen_hdr <= 1'b0;
    else if (hdr_vld)    seen_hdr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  in_burst <= 1'b0;
    else if (tx_vld && !tx_last) in_burst <= 1'b1;
    else if (tx_last)            in_burst <= 1'b0;
  end

  a_r5_pay_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    pay_vld |-> seen_hdr);

  a_r5_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> (pay_vld && frame_done));

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> frame_done);

  a_r2_pass_then_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hdr_pass |=> (hdr_vld && $past(rq_vld)));

  a_r4_cmd_allocated: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |-> (cmd_code >= 8'd1 && cmd_code <= 8'd4));

  a_r10_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rs_take |-> rs_busy);

  a_r11_tx_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !tx_last) |=> tx_vld);

  a_r9_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && !in_burst) |-> (tx_byte >= 8'd7));

  a_r12_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rs_accept |=> (rs_busy && !$past(rs_busy)));
endmodule

bind oemreq_frame_chk oemreq_frame_chk_sva u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rq_vld      (rq_vld),
  .hdr_vld     (hdr_vld),
  .cmd_code    (cmd_code),
  .pay_vld     (pay_vld),
  .pay_last    (pay_last),
  .frame_done  (frame_done),
  .frame_err   (frame_err),
  .rx_hdr_pass (rx_hdr_pass),
  .rs_accept   (rs_accept),
  .rs_take     (rs_take),
  .rs_busy     (rs_busy),
  .tx_vld      (tx_vld),
  .tx_byte     (tx_byte),
  .tx_last     (tx_last)
);

// File: tb/oemreq_frame_chk_tb_top.sv
module oemreq_frame_chk_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rq_vld = 1'b0, rq_last = 1'b0;
  logic [7:0] rq_byte = '0;
  logic       rs_start = 1'b0;
  logic [7:0] rs_cc = '0, rs_n = '0, rs_dat = '0;
  logic       hdr_vld, pay_vld, pay_last, frame_done, frame_err;
  logic [7:0] cmd_code, req_seq, pay_byte, tx_byte;
  logic [1:0] req_lun;
  logic       rs_take, rs_busy, tx_vld, tx_last;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_cmd = '0, m_seq = '0;
  logic [1:0] m_lun = '0;

  always #5 clk = ~clk;

  oemreq_frame_chk dut_i (
    .clk(clk), .rst_n(rst_n), .rq_vld(rq_vld), .rq_byte(rq_byte), .rq_last(rq_last),
    .hdr_vld(hdr_vld), .cmd_code(cmd_code), .req_lun(req_lun), .req_seq(req_seq),
    .pay_vld(pay_vld), .pay_byte(pay_byte), .pay_last(pay_last),
    .frame_done(frame_done), .frame_err(frame_err),
    .rs_start(rs_start), .rs_cc(rs_cc), .rs_n(rs_n), .rs_dat(rs_dat),
    .rs_take(rs_take), .rs_busy(rs_busy),
    .tx_vld(tx_vld), .tx_byte(tx_byte), .tx_last(tx_last)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_rx(input string tag, input bit eh, input bit ep, input logic [7:0] pb,
                        input bit epl, input bit ed, input bit ee);
    chk(tag, "hdr_vld", int'(hdr_vld), int'(eh));
    chk(tag, "pay_vld", int'(pay_vld), int'(ep));
    if (ep) chk(tag, "pay_byte", int'(pay_byte), int'(pb));
    chk(tag, "pay_last", int'(pay_last), int'(epl));
    chk(tag, "frame_done", int'(frame_done), int'(ed));
    chk(tag, "frame_err", int'(frame_err), int'(ee));
    chk(tag, "cmd_code", int'(cmd_code), int'(m_cmd));
    chk(tag, "req_lun", int'(req_lun), int'(m_lun));
    chk(tag, "req_seq", int'(req_seq), int'(m_seq));
    chk(tag, "tx_vld", int'(tx_vld), 0);
  endtask

  function automatic bq_t mk(input int len, input logic [5:0] fn, input logic [1:0] lun,
                             input logic [7:0] seq, input logic [7:0] cmd, input int npay);
    bq_t q;
    q.push_back(8'(len));
    q.push_back({fn, lun});
    q.push_back(seq);
    q.push_back(cmd);
    q.push_back(8'hCF);
    q.push_back(8'hC2);
    q.push_back(8'h00);
    for (int j = 0; j < npay; j++) q.push_back(8'(seq + 8'(j * 13) + 8'd3));
    return q;
  endfunction

  task automatic send_frame(input string tag, input bq_t fr, input int gap);
    int  nb = fr.size();
    bit  good = (nb >= 7) && (fr[1][7:2] == 6'h2E) && (fr[3] >= 8'd1) && (fr[3] <= 8'd4) &&
                (fr[4] == 8'hCF) && (fr[5] == 8'hC2) && (fr[6] == 8'h00);
    for (int k = 0; k < nb; k++) begin
      bit lastk = (k == nb - 1);
      bit ep = (k >= 7) && good;
      rq_vld = 1'b1; rq_byte = fr[k]; rq_last = lastk;
      @(negedge clk);
      rq_vld = 1'b0; rq_last = 1'b0;
      if (k == 6 && good) begin
        m_cmd = fr[3]; m_lun = fr[1][1:0]; m_seq = fr[2];
      end
      chk_rx(tag, (k == 6) && good, ep, fr[k], ep && lastk, lastk,
             lastk && !(good && nb == int'(fr[0]) + 1));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk_rx(tag, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      end
    end
  endtask

  function automatic logic [7:0] rdat(input logic [7:0] cc, input int j);
    return 8'(int'(cc) * 5 + j * 29 + 1);
  endfunction

  task automatic run_resp(input string tag, input logic [7:0] cc, input int n, input int dup_at);
    bq_t ex;
    int  total = 8 + n;
    ex.push_back(8'(7 + n));
    ex.push_back({6'h2F, m_lun});
    ex.push_back(m_seq);
    ex.push_back(m_cmd);
    ex.push_back(cc);
    ex.push_back(8'hCF);
    ex.push_back(8'hC2);
    ex.push_back(8'h00);
    for (int j = 0; j < n; j++) ex.push_back(rdat(cc, j));
    rs_start = 1'b1; rs_cc = cc; rs_n = 8'(n); rs_dat = '0;
    for (int k = 0; k <= total + 1; k++) begin
      @(negedge clk);
      rs_start = (k == dup_at);
      if (k == dup_at) begin rs_cc = ~cc; rs_n = 8'(n + 2); end
      rs_dat = (k >= 8 && k < total) ? rdat(cc, k - 8) : 8'h00;
      chk(tag, "rs_busy", int'(rs_busy), int'(k < total));
      chk(tag, "rs_take", int'(rs_take), int'(k >= 8 && k < total));
      chk(tag, "tx_vld", int'(tx_vld), int'(k >= 1 && k <= total));
      if (k >= 1 && k <= total) chk(tag, "tx_byte", int'(tx_byte), int'(ex[k-1]));
      chk(tag, "tx_last", int'(tx_last), int'(k == total));
      chk(tag, "frame_done", int'(frame_done), 0);
    end
    rs_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bq_t f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_rx("R1", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1", "rs_busy", int'(rs_busy), 0);
    chk("R1", "rs_take", int'(rs_take), 0);
    chk("R1", "tx_last", int'(tx_last), 0);

    send_frame("R2", mk(8, 6'h2E, 2'd2, 8'h21, 8'd1, 2), 1);
    send_frame("R5", mk(11, 6'h2E, 2'd0, 8'h44, 8'd2, 5), 0);
    send_frame("R7", mk(9, 6'h2E, 2'd1, 8'h07, 8'd4, 3), 2);
    // R8: back-to-back frames, no idle between them
    send_frame("R8", mk(7, 6'h2E, 2'd3, 8'h90, 8'd3, 1), 0);
    send_frame("R8", mk(6, 6'h2E, 2'd2, 8'h91, 8'd2, 0), 0);
    f = mk(9, 6'h2E, 2'd1, 8'h55, 8'd1, 3); f[5] = 8'hC3;
    send_frame("R3", f, 0);
    f = mk(8, 6'h2E, 2'd1, 8'h56, 8'd1, 2); f[6] = 8'h01;
    send_frame("R3", f, 1);
    send_frame("R2", mk(8, 6'h2F, 2'd0, 8'h57, 8'd2, 2), 0);
    send_frame("R4", mk(7, 6'h2E, 2'd0, 8'h60, 8'd0, 1), 0);
    send_frame("R4", mk(7, 6'h2E, 2'd0, 8'h61, 8'd5, 1), 0);
    send_frame("R4", mk(7, 6'h2E, 2'd1, 8'h62, 8'd3, 1), 0);
    send_frame("R6", mk(12, 6'h2E, 2'd2, 8'h70, 8'd2, 3), 0);
    send_frame("R6", mk(7, 6'h2E, 2'd2, 8'h71, 8'd2, 3), 0);
    f = mk(3, 6'h2E, 2'd0, 8'h72, 8'd1, 0);
    f = f[0:3];
    send_frame("R6", f, 1);

    send_frame("R9", mk(6, 6'h2E, 2'd3, 8'hA5, 8'd4, 0), 0);
    run_resp("R9", 8'h00, 0, -1);
    run_resp("R11", 8'h80, 1, -1);
    run_resp("R10", 8'hC1, 5, -1);
    run_resp("R12", 8'h33, 3, 3);
    // R13: a bad frame must not change mirrored fields
    send_frame("R13", mk(7, 6'h2E, 2'd0, 8'hEE, 8'd9, 1), 0);
    run_resp("R13", 8'h5A, 2, -1);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule